// File: doc/BRIEF.md
# Two-Register Machine Instruction Decoder

This block is the control decoder for a small two-register machine with an X register, a Y register, a display register and a program counter. It has no clock and no state. A 12-bit instruction word comes in, and out come the controls that steer the datapath in the same cycle: an ALU function select, the source of the ALU's second operand, write strobes for X, Y and the display, a PC jump select, a PC advance enable, and the 8-bit literal carried in the instruction.

Internally the word is cut into a 4-bit operation code (bits 11:8) and an 8-bit literal (bits 7:0). The operation code is expanded into a one-hot vector, and each control is formed from that vector. The ALU function is chosen by priority, and 00 (add) is what it falls back to. Both the instruction and the controls are plain combinational signals that are valid in the same cycle. There is no valid/ready handshake: the block never stalls and never holds data, so it cannot apply back-pressure. Operation codes E and F are undefined. They, and every don't-care position, resolve to the passive value, and an undefined code stops the PC, so the machine halts instead of running wild.

Top module: `isa_ctrl_decode`

## Requirements
- R1: `imm_o` always equals `instr_i[7:0]`, and the literal bits never affect any other output.
- R2: `pc_advance_o` is 0 for operation codes 0 (halt), E and F, and 1 for codes 1 through D.
- R3: `x_wr_o` is 1 exactly for codes 1, 3, 5, 7, 8, A and B.
- R4: `y_wr_o` is 1 exactly for codes 2, 3, 6, 9 and C.
- R5: `disp_wr_o` is 1 only for code 4, and `pc_jump_o` is 1 only for code D.
- R6: `alu_op_o` is 2'b11 for codes 1, 2, 3 and 5; 2'b10 for code 6; 2'b01 for codes A, B and C; and 2'b00 for every other code (ALU meaning: 00 add, 01 and, 10 pass A, 11 pass B).
- R7: `alu_b_imm_o` is 1 exactly for codes 1, 2, 3, 8 and B, and 0 for every other code.
- R8: For codes E and F every write strobe, `pc_jump_o` and `pc_advance_o` are 0.
- R9: A write to X or Y, a display write and a jump never occur in the same instruction (no code drives more than one of {X or Y write, display write, jump}).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word: code in bits 11:8, literal in bits 7:0 |
| alu_op_o | output | 2 | ALU function select |
| alu_b_imm_o | output | 1 | 1 selects the literal as the ALU second operand, 0 selects Y |
| x_wr_o | output | 1 | X register write strobe |
| y_wr_o | output | 1 | Y register write strobe |
| disp_wr_o | output | 1 | Display register write strobe |
| pc_jump_o | output | 1 | 1 loads the PC from the literal |
| pc_advance_o | output | 1 | PC write enable; 0 halts |
| imm_o | output | 8 | Literal field |

## Verification
The hardest thing to show is that the literal bits never leak into a control. A fault of that kind only appears for a particular pairing of code and literal, so a sweep that uses one literal per code can miss it. The stimulus runs every code with the literal at 00 and at FF, then draws several hundred random code/literal pairs from a fixed seed. The two undefined codes are among the directed cases, so the halt-on-unknown path is always covered.

// File: rtl/isa_ctrl_pkg.sv
package isa_ctrl_pkg;
  localparam int OP_W    = 4;
  localparam int IMM_W   = 8;
  localparam int INSTR_W = OP_W + IMM_W;
  localparam int N_OPS   = 2 ** OP_W;
  localparam int ALU_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'h0,
    OP_LDX   = 4'h1,
    OP_LDY   = 4'h2,
    OP_ZERO  = 4'h3,
    OP_SHOW  = 4'h4,
    OP_YTOX  = 4'h5,
    OP_XTOY  = 4'h6,
    OP_ADDXY = 4'h7,
    OP_ADDXI = 4'h8,
    OP_ADDYX = 4'h9,
    OP_ANDXY = 4'hA,
    OP_ANDXI = 4'hB,
    OP_ANDYX = 4'hC,
    OP_GOTO  = 4'hD
  } op_e;

  localparam int LAST_DEFINED = int'(OP_GOTO);

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD   = 2'b00,
    ALU_AND   = 2'b01,
    ALU_PASSA = 2'b10,
    ALU_PASSB = 2'b11
  } alu_e;

  typedef struct packed {
    alu_e alu_op;
    logic b_imm;
    logic x_wr;
    logic y_wr;
    logic disp_wr;
    logic pc_jump;
    logic pc_adv;
  } ctrl_t;
endpackage

// File: rtl/instr_fields.sv
module instr_fields
  import isa_ctrl_pkg::*;
#(
  parameter int W_OP  = OP_W,
  parameter int W_IMM = IMM_W,
  localparam int W_IN = W_OP + W_IMM
) (
  input  logic [W_IN-1:0]  word_i,
  output logic [W_OP-1:0]  op_o,
  output logic [W_IMM-1:0] lit_o
);
  assign op_o  = word_i[W_IN-1:W_IMM];
  assign lit_o = word_i[W_IMM-1:0];
endmodule

// File: rtl/op_onehot.sv
module op_onehot #(
  parameter int W_SEL = 4,
  localparam int N_OUT = 2 ** W_SEL
) (
  input  logic [W_SEL-1:0] sel_i,
  output logic [N_OUT-1:0] hot_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign hot_o[i] = (sel_i == W_SEL'(i));
  end
endmodule

// File: rtl/ctrl_encode.sv
module ctrl_encode
  import isa_ctrl_pkg::*;
(
  input  logic [N_OPS-1:0] hot_i,
  output ctrl_t            ctrl_o
);
  logic want_passb, want_passa, want_and;
  logic [LAST_DEFINED:1] live;

  // Every defined code except halt keeps the PC moving; undefined codes stop it.
  for (genvar k = 1; k <= LAST_DEFINED; k++) begin : g_live
    assign live[k] = hot_i[k];
  end

  assign want_passb = hot_i[OP_LDX] | hot_i[OP_LDY] | hot_i[OP_ZERO] | hot_i[OP_YTOX];
  assign want_passa = hot_i[OP_XTOY];
  assign want_and   = hot_i[OP_ANDXY] | hot_i[OP_ANDXI] | hot_i[OP_ANDYX];

  always_comb begin
    // Highest request wins; add is the fallback for everything else.
    if (want_passb)      ctrl_o.alu_op = ALU_PASSB;
    else if (want_passa) ctrl_o.alu_op = ALU_PASSA;
    else if (want_and)   ctrl_o.alu_op = ALU_AND;
    else                 ctrl_o.alu_op = ALU_ADD;

    ctrl_o.b_imm   = hot_i[OP_LDX] | hot_i[OP_LDY] | hot_i[OP_ZERO]
                   | hot_i[OP_ADDXI] | hot_i[OP_ANDXI];
    ctrl_o.x_wr    = hot_i[OP_LDX] | hot_i[OP_ZERO] | hot_i[OP_YTOX]
                   | hot_i[OP_ADDXY] | hot_i[OP_ADDXI] | hot_i[OP_ANDXY]
                   | hot_i[OP_ANDXI];
    ctrl_o.y_wr    = hot_i[OP_LDY] | hot_i[OP_ZERO] | hot_i[OP_XTOY]
                   | hot_i[OP_ADDYX] | hot_i[OP_ANDYX];
    ctrl_o.disp_wr = hot_i[OP_SHOW];
    ctrl_o.pc_jump = hot_i[OP_GOTO];
    ctrl_o.pc_adv  = |live;
  end
endmodule

// File: rtl/isa_ctrl_decode.sv
module isa_ctrl_decode
  import isa_ctrl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ALU_W-1:0]   alu_op_o,
  output logic               alu_b_imm_o,
  output logic               x_wr_o,
  output logic               y_wr_o,
  output logic               disp_wr_o,
  output logic               pc_jump_o,
  output logic               pc_advance_o,
  output logic [IMM_W-1:0]   imm_o
);
  logic [OP_W-1:0]  op_code;
  logic [N_OPS-1:0] op_hot;
  ctrl_t            ctrl;

  instr_fields #(.W_OP(OP_W), .W_IMM(IMM_W)) u_fields (
    .word_i (instr_i),
    .op_o   (op_code),
    .lit_o  (imm_o)
  );

  op_onehot #(.W_SEL(OP_W)) u_hot (
    .sel_i (op_code),
    .hot_o (op_hot)
  );

  ctrl_encode u_enc (
    .hot_i  (op_hot),
    .ctrl_o (ctrl)
  );

  assign alu_op_o     = ctrl.alu_op;
  assign alu_b_imm_o  = ctrl.b_imm;
  assign x_wr_o       = ctrl.x_wr;
  assign y_wr_o       = ctrl.y_wr;
  assign disp_wr_o    = ctrl.disp_wr;
  assign pc_jump_o    = ctrl.pc_jump;
  assign pc_advance_o = ctrl.pc_adv;
endmodule

// File: rtl/isa_ctrl_decode_chk.sv
module isa_ctrl_decode_chk
  import isa_ctrl_pkg::*;
(
  input logic [INSTR_W-1:0] instr_i,
  input logic [N_OPS-1:0]   op_hot,
  input logic [ALU_W-1:0]   alu_op_o,
  input logic               alu_b_imm_o,
  input logic               x_wr_o,
  input logic               y_wr_o,
  input logic               disp_wr_o,
  input logic               pc_jump_o,
  input logic               pc_advance_o,
  input logic [IMM_W-1:0]   imm_o
);
  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_hot_single_r2: assert ($onehot(op_hot))
        else $error("decoder line vector not one-hot");
      p_literal_r1: assert (imm_o == instr_i[IMM_W-1:0])
        else $error("literal output differs from instruction");
      p_undef_quiet_r8: assert (!(instr_i[INSTR_W-1:INSTR_W-2] == 2'b11 && instr_i[IMM_W+1])
                                || !(x_wr_o | y_wr_o | disp_wr_o | pc_jump_o | pc_advance_o))
        else $error("undefined code produced an action");
      p_one_action_r9: assert ($countones({x_wr_o | y_wr_o, disp_wr_o, pc_jump_o}) <= 1)
        else $error("more than one kind of action at once");
      p_halt_still_r2: assert (pc_advance_o
                               || !(x_wr_o | y_wr_o | disp_wr_o | pc_jump_o))
        else $error("action while the PC is stopped");
      p_disp_passive_r5: assert (!disp_wr_o || (alu_op_o == 2'b00 && !alu_b_imm_o))
        else $error("display write with a non-default ALU setting");
      p_jump_advances_r5: assert (!pc_jump_o || pc_advance_o)
        else $error("jump without PC enable");
    end
  end
endmodule

bind isa_ctrl_decode isa_ctrl_decode_chk u_chk (
  .instr_i      (instr_i),
  .op_hot       (op_hot),
  .alu_op_o     (alu_op_o),
  .alu_b_imm_o  (alu_b_imm_o),
  .x_wr_o       (x_wr_o),
  .y_wr_o       (y_wr_o),
  .disp_wr_o    (disp_wr_o),
  .pc_jump_o    (pc_jump_o),
  .pc_advance_o (pc_advance_o),
  .imm_o        (imm_o)
);

// File: tb/isa_ctrl_decode_bench.sv
module isa_ctrl_decode_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] instr;
  logic [1:0]  alu_op;
  logic        b_imm, x_wr, y_wr, d_wr, jmp, adv;
  logic [7:0]  imm;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  isa_ctrl_decode u_isa_ctrl_decode (
    .instr_i      (instr),
    .alu_op_o     (alu_op),
    .alu_b_imm_o  (b_imm),
    .x_wr_o       (x_wr),
    .y_wr_o       (y_wr),
    .disp_wr_o    (d_wr),
    .pc_jump_o    (jmp),
    .pc_advance_o (adv),
    .imm_o        (imm)
  );

  function automatic logic [1:0] exp_alu(input logic [3:0] op);
    case (op)
      4'h1, 4'h2, 4'h3, 4'h5: return 2'b11;
      4'h6:                   return 2'b10;
      4'hA, 4'hB, 4'hC:       return 2'b01;
      default:                return 2'b00;
    endcase
  endfunction
  function automatic logic exp_bimm(input logic [3:0] op);
    return op inside {4'h1, 4'h2, 4'h3, 4'h8, 4'hB};
  endfunction
  function automatic logic exp_x(input logic [3:0] op);
    return op inside {4'h1, 4'h3, 4'h5, 4'h7, 4'h8, 4'hA, 4'hB};
  endfunction
  function automatic logic exp_y(input logic [3:0] op);
    return op inside {4'h2, 4'h3, 4'h6, 4'h9, 4'hC};
  endfunction
  function automatic logic exp_adv(input logic [3:0] op);
    return (op != 4'h0) && (op <= 4'hD);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h instr=%03h", req, what, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] lit);
    @(negedge clk);
    instr = {op, lit};
    #1;
    chk("R1", "imm", int'(imm), int'(lit));
    chk("R2", "pc_advance", int'(adv), int'(exp_adv(op)));
    chk("R3", "x_wr", int'(x_wr), int'(exp_x(op)));
    chk("R4", "y_wr", int'(y_wr), int'(exp_y(op)));
    chk("R5", "disp_wr", int'(d_wr), int'(op == 4'h4));
    chk("R5", "pc_jump", int'(jmp), int'(op == 4'hD));
    chk("R6", "alu_op", int'(alu_op), int'(exp_alu(op)));
    chk("R7", "b_imm", int'(b_imm), int'(exp_bimm(op)));
    if (op >= 4'hE)
      chk("R8", "undef any action", int'(x_wr | y_wr | d_wr | jmp | adv), 0);
    chk("R9", "action kinds", int'($countones({x_wr | y_wr, d_wr, jmp}) <= 1), 1);
  endtask

  always @(posedge clk) begin
    if (!rst && !done) begin
      cycles++;
      if (cycles > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int unused_seed;
    instr = 12'h000;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // Idle word is a halt: nothing may move (R2, R8 style quiet state).
    chk("R2", "idle pc_advance", int'(adv), 0);
    chk("R3", "idle x_wr", int'(x_wr | y_wr | d_wr | jmp), 0);
    // Directed: every code with both literal extremes (R1 literal isolation).
    for (int op = 0; op < 16; op++) begin
      apply(4'(op), 8'h00);
      apply(4'(op), 8'hFF);
      apply(4'(op), 8'hA5);
    end
    // Random code/literal pairs.
    for (int n = 0; n < 600; n++) begin
      apply(4'($urandom_range(15, 0)), 8'($urandom));
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule